// File: doc/BRIEF.md
# Reset Synchronizer and Mode Strap Latch

This block turns a raw, active-low system reset that may arrive at any time into an active-high reset that is aligned to the clock and lasts a whole number of clock periods. While the reset is held, and for a few clocks after it is released, the block samples a set of strap inputs. From them it derives three mode flags: enhanced versus compatible operation, a global high-impedance test mode, and a queue-status output mode. The flags stay constant until the next reset.

The block also sequences the bus control pins (bus status, read and write strobes, lock) through reset. On the first clock of reset it forces them to their inactive high level. For the remainder of reset it floats them. Once reset ends, the core takes over those pins. A single-cycle start pulse marks the point at which instruction fetch may begin.

In the text below, the "release edge" A is the first rising clock edge at which `rst_ni` is sampled high after it has been sampled low.

Top module: `rst_strap_ctrl`

## Requirements
- R1: `rst_o` after any rising edge equals the inverse of `rst_ni` as sampled two rising edges earlier. It therefore rises on the second edge after `rst_ni` is first sampled low and falls on edge A+1.
- R2: `rst_o` stays high for exactly as many clock periods as the number of rising edges at which `rst_ni` was sampled low.
- R3: `enh_mode_o` is 1 from edge A+4 onward when `test_strap_i` was 1 at edge A and 0 at edge A+4. Every other pair of values gives 0. The flag is 0 from the second edge of reset until edge A+4.
- R4: `hiz_test_o` is 1 when `cs_hi_strap_ni` and `cs_lo_strap_ni` were both 0 at edge A, and it holds until a later reset. While `hiz_test_o` is 1, `ctl_float_o` is 1 and `ctl_force_o` is 0.
- R5: `qstat_mode_o` is 1 when `rd_strap_i` was 0 at edge A, and 0 when it was 1.
- R6: `ctl_force_o` is 1 for exactly the first clock period in which `rst_o` is high, unless the test mode is selected, and is 0 at every other time.
- R7: `ctl_float_o` is 1 in every clock period of `rst_o` after the first. It is 0 once `rst_o` has fallen, unless the test mode is selected.
- R8: `start_o` is a single-cycle pulse that is high in the clock period that follows edge A+7, and is low at all other times.
- R9: Changes on any strap input while `rst_o` is low leave `hiz_test_o` and `qstat_mode_o` unchanged, and leave `enh_mode_o` unchanged from edge A+4 onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Raw system reset, active low, asynchronous to `clk_i` |
| test_strap_i | input | 1 | Mode strap: high at the release edge and low four clocks later selects enhanced mode |
| cs_hi_strap_ni | input | 1 | Upper chip-select strap, active low |
| cs_lo_strap_ni | input | 1 | Lower chip-select strap, active low |
| rd_strap_i | input | 1 | Read-strobe strap; low selects queue-status outputs |
| rst_o | output | 1 | Synchronized active-high reset |
| enh_mode_o | output | 1 | 1 = enhanced mode, 0 = compatible mode |
| hiz_test_o | output | 1 | 1 = every output of the chip floats |
| qstat_mode_o | output | 1 | 1 = queue status replaces the address-latch and write strobes |
| ctl_force_o | output | 1 | Drive the bus control pins to their inactive high level |
| ctl_float_o | output | 1 | Float the bus control pins |
| start_o | output | 1 | One-cycle pulse: instruction fetch may begin |

## Verification
Each result is due at a fixed number of edges after its cause. `rst_o` changes two edges after a change in the sampled `rst_ni`. `ctl_force_o` lasts one period starting at the edge where `rst_o` rises. The strap flags settle at edge A, except `enh_mode_o`, which settles at A+4. `start_o` appears at A+7. The bench numbers every rising edge of a reset sequence, sets and changes inputs 1 ns after an edge, and compares each output 1 ns after every edge against a value computed from that edge number. This makes every latency above a cycle-exact check rather than an eventual one. After each release, the straps are toggled to show that the latched flags do not follow them.

// File: rtl/rsm_pkg.sv
`timescale 1ns/1ps
package rsm_pkg;
  typedef struct packed {
    logic test;
    logic cs_hi_n;
    logic cs_lo_n;
    logic rd;
  } strap_t;

  typedef struct packed {
    logic enh;
    logic hiz;
    logic qstat;
  } mode_t;
endpackage

// File: rtl/rsm_sync.sv
`timescale 1ns/1ps
module rsm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic first_o,
  output logic sync_o
);
  logic [STAGES-1:0] q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_head
      always_ff @(posedge clk_i) q[i] <= rst_ni;
    end else begin : g_tail
      always_ff @(posedge clk_i) q[i] <= q[i-1];
    end
  end

  assign first_o = q[0];
  assign sync_o  = q[STAGES-1];
endmodule

// File: rtl/rsm_strap.sv
`timescale 1ns/1ps
module rsm_strap
  import rsm_pkg::*;
#(
  parameter int ENH_DLY   = 4,
  parameter int START_DLY = 7
) (
  input  logic   clk_i,
  input  logic   seen_i,   // raw reset seen high by first sync stage
  input  strap_t straps_i,
  output mode_t  mode_o,
  output logic   start_o
);
  localparam int CW = $clog2(START_DLY + 2);
  localparam logic [CW-1:0] CNT_SAT  = CW'(START_DLY + 1);
  localparam logic [CW-1:0] ENH_AT   = CW'(ENH_DLY - 1);
  localparam logic [CW-1:0] START_AT = CW'(START_DLY);

  strap_t        cap;
  logic          enh_q;
  logic [CW-1:0] cnt;

  // track straps until the release edge, then freeze
  always_ff @(posedge clk_i) begin
    if (!seen_i) cap <= straps_i;
  end

  always_ff @(posedge clk_i) begin
    if (!seen_i)             cnt <= '0;
    else if (cnt != CNT_SAT) cnt <= cnt + 1'b1;
  end

  // second look at the test strap ENH_DLY edges after release
  always_ff @(posedge clk_i) begin
    if (!seen_i)            enh_q <= 1'b0;
    else if (cnt == ENH_AT) enh_q <= cap.test & ~straps_i.test;
  end

  assign mode_o.enh   = enh_q;
  assign mode_o.hiz   = ~cap.cs_hi_n & ~cap.cs_lo_n;
  assign mode_o.qstat = ~cap.rd;
  assign start_o      = (cnt == START_AT);
endmodule

// File: rtl/rsm_bus_seq.sv
`timescale 1ns/1ps
module rsm_bus_seq (
  input  logic clk_i,
  input  logic sync_n_i,
  input  logic hiz_i,
  output logic rst_o,
  output logic force_o,
  output logic float_o
);
  logic rst_d;

  always_ff @(posedge clk_i) rst_d <= ~sync_n_i;

  assign rst_o   = ~sync_n_i;
  assign force_o = rst_o & ~rst_d & ~hiz_i;
  assign float_o = (rst_o & rst_d) | hiz_i;
endmodule

// File: rtl/rst_strap_ctrl.sv
`timescale 1ns/1ps
module rst_strap_ctrl
  import rsm_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int ENH_DLY     = 4,
  parameter int START_DLY   = 7
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic test_strap_i,
  input  logic cs_hi_strap_ni,
  input  logic cs_lo_strap_ni,
  input  logic rd_strap_i,
  output logic rst_o,
  output logic enh_mode_o,
  output logic hiz_test_o,
  output logic qstat_mode_o,
  output logic ctl_force_o,
  output logic ctl_float_o,
  output logic start_o
);
  logic   seen, sync_n;
  strap_t straps;
  mode_t  mode;

  assign straps = '{test: test_strap_i, cs_hi_n: cs_hi_strap_ni,
                    cs_lo_n: cs_lo_strap_ni, rd: rd_strap_i};

  rsm_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .first_o(seen),
    .sync_o (sync_n)
  );

  rsm_strap #(.ENH_DLY(ENH_DLY), .START_DLY(START_DLY)) u_strap (
    .clk_i   (clk_i),
    .seen_i  (seen),
    .straps_i(straps),
    .mode_o  (mode),
    .start_o (start_o)
  );

  rsm_bus_seq u_seq (
    .clk_i   (clk_i),
    .sync_n_i(sync_n),
    .hiz_i   (mode.hiz),
    .rst_o   (rst_o),
    .force_o (ctl_force_o),
    .float_o (ctl_float_o)
  );

  assign enh_mode_o   = mode.enh;
  assign hiz_test_o   = mode.hiz;
  assign qstat_mode_o = mode.qstat;
endmodule

// File: rtl/rst_strap_ctrl_chk.sv
`timescale 1ns/1ps
module rst_strap_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic test_strap_i,
  input logic rst_o,
  input logic enh_mode_o,
  input logic hiz_test_o,
  input logic qstat_mode_o,
  input logic ctl_force_o,
  input logic ctl_float_o,
  input logic start_o
);
  // armed once the raw reset has been low for two edges
  logic ni_q, primed;
  always_ff @(posedge clk_i) begin
    ni_q   <= rst_ni;
    primed <= primed | (~rst_ni & ~ni_q);
  end

  AST_RST_TRACK: assert property (@(posedge clk_i) disable iff (!primed)
    rst_o == !$past(rst_ni, 2)); // R1
  AST_FORCE_ONE: assert property (@(posedge clk_i) disable iff (!primed)
    ctl_force_o |=> !ctl_force_o); // R6
  AST_FORCE_ENTRY: assert property (@(posedge clk_i) disable iff (!primed)
    $rose(rst_o) && !hiz_test_o |-> ctl_force_o); // R6
  AST_FLOAT_HOLD: assert property (@(posedge clk_i) disable iff (!primed)
    rst_o && $past(rst_o) |-> ctl_float_o); // R7
  AST_HIZ_QUIET: assert property (@(posedge clk_i) disable iff (!primed)
    hiz_test_o |-> ctl_float_o && !ctl_force_o); // R4
  AST_ENH_RISE: assert property (@(posedge clk_i) disable iff (!primed)
    $rose(enh_mode_o) |-> !$past(test_strap_i) && !rst_o); // R3
  AST_ENH_CLEAR: assert property (@(posedge clk_i) disable iff (!primed)
    $fell(enh_mode_o) |-> rst_o); // R3
  AST_MODE_HOLD: assert property (@(posedge clk_i) disable iff (!primed)
    !rst_o |-> $stable(hiz_test_o) && $stable(qstat_mode_o)); // R9
  AST_START_ONE: assert property (@(posedge clk_i) disable iff (!primed)
    start_o |=> !start_o); // R8
  AST_START_RUN: assert property (@(posedge clk_i) disable iff (!primed)
    start_o |-> !rst_o); // R8
endmodule

bind rst_strap_ctrl rst_strap_ctrl_chk u_chk (.*);

// File: tb/rst_strap_ctrl_test.sv
`timescale 1ns/1ps
module rst_strap_ctrl_test;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic test_s = 1'b1, csh_n = 1'b1, csl_n = 1'b1, rd_s = 1'b1;
  logic rst_o, enh, hiz, qs, frc, flt, start;
  int   n_chk = 0, n_bad = 0;
  bit   done = 1'b0;

  always #2.5 clk = ~clk;

  rst_strap_ctrl uut (
    .clk_i(clk), .rst_ni(rst_ni), .test_strap_i(test_s),
    .cs_hi_strap_ni(csh_n), .cs_lo_strap_ni(csl_n), .rd_strap_i(rd_s),
    .rst_o(rst_o), .enh_mode_o(enh), .hiz_test_o(hiz), .qstat_mode_o(qs),
    .ctl_force_o(frc), .ctl_float_o(flt), .start_o(start)
  );

  // {test@A, test@A+4, cs_hi_n, cs_lo_n, rd, exp enh, exp hiz, exp qstat}
  localparam logic [7:0] VEC [8] = '{
    8'b10111_100, 8'b11111_000, 8'b00111_000, 8'b01111_000,
    8'b10001_110, 8'b10110_101, 8'b00010_001, 8'b10101_100
  };

  task automatic chk(input string tag, input int e, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s edge %0d: actual %b expected %b", tag, e, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic run_reset(input int lo, input logic ta, input logic ta4,
                           input logic ch, input logic cl, input logic rd,
                           input logic x_enh, input logic x_hiz, input logic x_qs);
    int a, hi_cnt;
    a = lo + 1;
    hi_cnt = 0;
    rst_ni = 1'b0; test_s = ta; csh_n = ch; csl_n = cl; rd_s = rd;
    for (int e = 1; e <= a + 9; e++) begin
      tick();
      if (rst_o) hi_cnt++;
      chk("R1 rst_o", e, rst_o, (e >= 2 && e <= a));
      if (e >= 2) begin
        chk("R4 hiz", e, hiz, x_hiz);
        chk("R5 qstat", e, qs, x_qs);
        chk("R6 force", e, frc, (e == 2) && !x_hiz);
        chk("R7 float", e, flt, (e >= 3 && e <= a) || x_hiz);
        chk("R3 enh", e, enh, (e >= a + 4) ? x_enh : 1'b0);
      end
      chk("R8 start", e, start, e == a + 7);
      if (e == lo) rst_ni = 1'b1;
      if (e == a)  test_s = ta4;
    end
    chk("R2 rst length", hi_cnt, 1'(hi_cnt == lo), 1'b1);
    // R9: strap wiggles after reset change nothing
    for (int k = 0; k < 4; k++) begin
      test_s = ~test_s; csh_n = k[0]; csl_n = k[1]; rd_s = ~rd_s;
      tick();
      chk("R9 enh", k, enh, x_enh);
      chk("R9 hiz", k, hiz, x_hiz);
      chk("R9 qstat", k, qs, x_qs);
      chk("R9 rst_o", k, rst_o, 1'b0);
    end
  endtask

  initial begin
    repeat (4) tick();
    rst_ni = 1'b1;
    repeat (10) tick();
    chk("R1 reset state rst_o", 0, rst_o, 1'b0);
    chk("R3 reset state enh", 0, enh, 1'b0);
    chk("R4 reset state hiz", 0, hiz, 1'b0);
    chk("R5 reset state qstat", 0, qs, 1'b0);
    chk("R6 reset state force", 0, frc, 1'b0);
    chk("R7 reset state float", 0, flt, 1'b0);
    for (int i = 0; i < 8; i++) begin
      run_reset(1 + (i % 4), VEC[i][7], VEC[i][6], VEC[i][5], VEC[i][4], VEC[i][3],
                VEC[i][2], VEC[i][1], VEC[i][0]);
    end
    // every strap combination, several release timings
    for (int c = 0; c < 32; c++) begin
      logic ta, ta4, ch, cl, rd;
      {ta, ta4, ch, cl, rd} = 5'(c);
      run_reset(1 + (c % 6), ta, ta4, ch, cl, rd, ta & ~ta4, ~ch & ~cl, ~rd);
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule